// File: doc/BRIEF.md
# Nested Event Priority Controller

This block arbitrates among a bank of event levels for a processor core. Each level has one request line, and a lower level index means higher priority. A request is captured into a latch register. Latched levels are filtered by a per-level enable mask and by a global switch that covers the general-purpose levels. The controller then issues the most urgent surviving level to the core, provided that level outranks everything the core is already serving.

Serving levels are recorded in a pending register, so interrupted work stays visible while more urgent work runs. A return strobe from the core retires the most urgent serving level, and less urgent latched work can then be issued.

Software sees the latch, enable and pending registers through a small register port that carries a privilege flag. The enable and pending registers are reserved for privileged accesses. The pending register is never writable.

Top module: `evt_nest_ctrl`

## Requirements
- R1: Reset leaves the latch, enable mask and pending registers at zero, drops `acc_valid`, and leaves the global general-purpose switch on.
- R2: A high `evt_req[i]` in a cycle sets latch bit i at the next clock edge. A read with `reg_sel` = 0 returns the latch register in any privilege mode.
- R3: A level i is issued when its latch and mask bits are both set and i is below the lowest-index set pending bit (any i if none is set). Among such levels the lowest index wins. At the same edge latch bit i clears, pending bit i sets, and `acc_valid` rises with `acc_idx` = i. A request arriving in that same cycle re-sets the latch bit.
- R4: A level whose mask bit is clear is never issued, and its latch bit stays set.
- R5: A software write with `reg_sel` = 0 loads `reg_wdata[i]` into latch bit i only where mask bit i is clear. Where mask bit i is set the write leaves that bit unchanged. A request on the same bit in the same cycle takes precedence.
- R6: The mask register (`reg_sel` = 1) is written only when `reg_sup` is high. The pending register (`reg_sel` = 2) is never written by software. Reads of either register with `reg_sup` low return zero, and `reg_sel` = 3 reads zero.
- R7: A high `evt_ret` clears the lowest-index set pending bit at the next edge. In the same edge an issue may set a lower-index bit.
- R8: While a level is pending, only a lower-index level can be issued. Equal or higher indices wait until returns have cleared every pending bit at or below their index.
- R9: Levels at index GP_FIRST and above are issued only while the global switch is on. A `gie_off` pulse turns the switch off and a `gie_on` pulse turns it on, with off winning if both arrive together. The switch leaves the mask register unchanged.
- R10: `acc_valid` is high for exactly the cycle after each issuing edge and is low whenever nothing was issued at the previous edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_req | input | NUM_LVL | Per-level event request lines |
| evt_ret | input | 1 | Return strobe retiring the most urgent serving level |
| gie_on | input | 1 | Turn general-purpose levels on globally |
| gie_off | input | 1 | Turn general-purpose levels off globally |
| reg_wr | input | 1 | Register write strobe |
| reg_sup | input | 1 | Access is privileged |
| reg_sel | input | 2 | Register select: 0 latch, 1 mask, 2 pending, 3 none |
| reg_wdata | input | NUM_LVL | Register write data |
| reg_rdata | output | NUM_LVL | Register read data for the selected register |
| acc_valid | output | 1 | One-cycle strobe: a level was issued |
| acc_idx | output | IDX_W | Index of the issued level |

## Verification
The bench builds the controller with 16 levels and the general-purpose boundary at level 7. With this split, randomly drawn requests regularly fall on both sides of the global switch, so its gating is exercised alongside the unconditional high-priority levels. Sixteen levels are also few enough that sparse random requests, returns and mask writes repeatedly build nesting three and four deep. They also regularly hit same-cycle collisions: a request on an issuing bit, a return with an issue, and a latch write on both masked and unmasked bits.

// File: rtl/evt_nest_pkg.sv
package evt_nest_pkg;

   typedef enum logic [1:0] {
      SEL_LATCH = 2'd0,
      SEL_MASK  = 2'd1,
      SEL_PEND  = 2'd2,
      SEL_NONE  = 2'd3
   } sel_e;

endpackage

// File: rtl/evt_lowest_pick.sv
module evt_lowest_pick #(
   parameter int N = 16,
   parameter int W = 4
) (
   input  logic [N-1:0] vec,
   output logic         found,
   output logic [W-1:0] idx,
   output logic [N-1:0] onehot
);

   always_comb begin
      found  = 1'b0;
      idx    = '0;
      onehot = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (vec[i]) begin
            found     = 1'b1;
            idx       = W'(i);
            onehot    = '0;
            onehot[i] = 1'b1;
         end
      end
   end

endmodule

// File: rtl/evt_latch_bank.sv
module evt_latch_bank #(
   parameter int N = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] req,
   input  logic         sw_wr,
   input  logic [N-1:0] sw_data,
   input  logic [N-1:0] mask,
   input  logic [N-1:0] acc_clr,
   output logic [N-1:0] latch_q
);

   logic [N-1:0] latch_d;

   for (genvar i = 0; i < N; i++) begin : g_bit
      always_comb begin
         if (sw_wr && !mask[i])
            latch_d[i] = req[i] | sw_data[i];
         else
            latch_d[i] = req[i] | (latch_q[i] & ~acc_clr[i]);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) latch_q <= '0;
      else        latch_q <= latch_d;
   end

endmodule

// File: rtl/evt_pend_track.sv
module evt_pend_track #(
   parameter int N = 16,
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] acc_set,
   input  logic         ret,
   output logic [N-1:0] pend_q,
   output logic [N-1:0] outrank
);

   logic         any_pend;
   logic [W-1:0] low_idx;
   logic [N-1:0] low_oh;

   evt_lowest_pick #(.N(N), .W(W)) u_low (
      .vec    (pend_q),
      .found  (any_pend),
      .idx    (low_idx),
      .onehot (low_oh)
   );

   // Bits strictly below the most urgent serving level; all bits when idle.
   assign outrank = any_pend ? (low_oh - N'(1)) : '1;

   logic [N-1:0] retire;
   assign retire = ret ? low_oh : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q <= '0;
      else        pend_q <= (pend_q & ~retire) | acc_set;
   end

   logic unused_idx;
   assign unused_idx = ^low_idx;

endmodule

// File: rtl/evt_nest_ctrl.sv
module evt_nest_ctrl
   import evt_nest_pkg::*;
#(
   parameter int NUM_LVL  = 16,
   parameter int GP_FIRST = 7,
   parameter int IDX_W    = (NUM_LVL > 1) ? $clog2(NUM_LVL) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_LVL-1:0] evt_req,
   input  logic               evt_ret,
   input  logic               gie_on,
   input  logic               gie_off,
   input  logic               reg_wr,
   input  logic               reg_sup,
   input  logic [1:0]         reg_sel,
   input  logic [NUM_LVL-1:0] reg_wdata,
   output logic [NUM_LVL-1:0] reg_rdata,
   output logic               acc_valid,
   output logic [IDX_W-1:0]   acc_idx
);

   if (NUM_LVL < 2 || NUM_LVL > 64) begin : g_bad_lvl
      $error("NUM_LVL must lie in 2..64");
   end
   if (GP_FIRST < 0 || GP_FIRST > NUM_LVL) begin : g_bad_gp
      $error("GP_FIRST must lie in 0..NUM_LVL");
   end
   if (IDX_W < $clog2(NUM_LVL)) begin : g_bad_w
      $error("IDX_W too narrow for NUM_LVL");
   end

   sel_e sel;
   assign sel = sel_e'(reg_sel);

   logic [NUM_LVL-1:0] latch_q;
   logic [NUM_LVL-1:0] mask_q;
   logic [NUM_LVL-1:0] pend_q;
   logic [NUM_LVL-1:0] outrank;
   logic               gen_q;

   // Per-level gate from the global switch.
   logic [NUM_LVL-1:0] gp_gate;
   for (genvar i = 0; i < NUM_LVL; i++) begin : g_gate
      if (i >= GP_FIRST) begin : g_gp
         assign gp_gate[i] = gen_q;
      end else begin : g_fixed
         assign gp_gate[i] = 1'b1;
      end
   end

   logic [NUM_LVL-1:0] cand;
   logic               win_found;
   logic [IDX_W-1:0]   win_idx;
   logic [NUM_LVL-1:0] win_oh;

   assign cand = latch_q & mask_q & gp_gate & outrank;

   evt_lowest_pick #(.N(NUM_LVL), .W(IDX_W)) u_win (
      .vec    (cand),
      .found  (win_found),
      .idx    (win_idx),
      .onehot (win_oh)
   );

   evt_latch_bank #(.N(NUM_LVL)) u_latch (
      .clk     (clk),
      .rst_n   (rst_n),
      .req     (evt_req),
      .sw_wr   (reg_wr && sel == SEL_LATCH),
      .sw_data (reg_wdata),
      .mask    (mask_q),
      .acc_clr (win_oh),
      .latch_q (latch_q)
   );

   evt_pend_track #(.N(NUM_LVL), .W(IDX_W)) u_pend (
      .clk     (clk),
      .rst_n   (rst_n),
      .acc_set (win_oh),
      .ret     (evt_ret),
      .pend_q  (pend_q),
      .outrank (outrank)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q    <= '0;
         gen_q     <= 1'b1;
         acc_valid <= 1'b0;
         acc_idx   <= '0;
      end else begin
         if (reg_wr && reg_sup && sel == SEL_MASK) mask_q <= reg_wdata;
         if (gie_off)     gen_q <= 1'b0;
         else if (gie_on) gen_q <= 1'b1;
         acc_valid <= win_found;
         if (win_found) acc_idx <= win_idx;
      end
   end

   always_comb begin
      unique case (sel)
         SEL_LATCH: reg_rdata = latch_q;
         SEL_MASK:  reg_rdata = reg_sup ? mask_q : '0;
         SEL_PEND:  reg_rdata = reg_sup ? pend_q : '0;
         default:   reg_rdata = '0;
      endcase
   end

endmodule

// File: rtl/evt_nest_chk.sv
module evt_nest_chk #(
   parameter int NUM_LVL  = 16,
   parameter int GP_FIRST = 7,
   parameter int IDX_W    = 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic [NUM_LVL-1:0] latch_q,
   input logic [NUM_LVL-1:0] mask_q,
   input logic [NUM_LVL-1:0] pend_q,
   input logic               gen_q,
   input logic               acc_valid,
   input logic [IDX_W-1:0]   acc_idx,
   input logic               evt_ret,
   input logic               reg_wr,
   input logic               reg_sup
);

   function automatic logic bit_at(input logic [NUM_LVL-1:0] v, input logic [IDX_W-1:0] k);
      return v[k];
   endfunction

   function automatic logic [NUM_LVL-1:0] upto(input logic [IDX_W-1:0] k);
      logic [NUM_LVL-1:0] m;
      for (int i = 0; i < NUM_LVL; i++) m[i] = (i <= int'(k));
      return m;
   endfunction

   a_r3_issued_was_latched: assert property (@(posedge clk) disable iff (!rst_n)
      acc_valid |-> bit_at($past(latch_q), acc_idx) && bit_at(pend_q, acc_idx));

   a_r4_issued_was_enabled: assert property (@(posedge clk) disable iff (!rst_n)
      acc_valid |-> bit_at($past(mask_q), acc_idx));

   a_r8_issue_outranks: assert property (@(posedge clk) disable iff (!rst_n)
      acc_valid |-> (($past(pend_q) & upto(acc_idx)) == '0));

   a_r9_gp_needs_switch: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && int'(acc_idx) >= GP_FIRST) |-> $past(gen_q));

   a_r6_pend_grows_by_one: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(pend_q & ~$past(pend_q)) <= 1);

   a_r6_user_mask_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && !reg_sup) |=> $stable(mask_q));

   a_r7_return_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_ret && pend_q != '0) |=> $countones(pend_q) <= $countones($past(pend_q)));

endmodule

bind evt_nest_ctrl evt_nest_chk #(
   .NUM_LVL  (NUM_LVL),
   .GP_FIRST (GP_FIRST),
   .IDX_W    (IDX_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .latch_q   (latch_q),
   .mask_q    (mask_q),
   .pend_q    (pend_q),
   .gen_q     (gen_q),
   .acc_valid (acc_valid),
   .acc_idx   (acc_idx),
   .evt_ret   (evt_ret),
   .reg_wr    (reg_wr),
   .reg_sup   (reg_sup)
);

// File: tb/test_evt_nest_ctrl.sv
module test_evt_nest_ctrl;

   localparam int N  = 16;
   localparam int GP = 7;
   localparam int W  = 4;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [N-1:0] evt_req = '0;
   logic         evt_ret = 1'b0;
   logic         gie_on = 1'b0;
   logic         gie_off = 1'b0;
   logic         reg_wr = 1'b0;
   logic         reg_sup = 1'b1;
   logic [1:0]   reg_sel = 2'd0;
   logic [N-1:0] reg_wdata = '0;
   logic [N-1:0] reg_rdata;
   logic         acc_valid;
   logic [W-1:0] acc_idx;

   always #4 clk = ~clk;

   evt_nest_ctrl #(.NUM_LVL(N), .GP_FIRST(GP)) i_evt_nest_ctrl (
      .clk(clk), .rst_n(rst_n), .evt_req(evt_req), .evt_ret(evt_ret),
      .gie_on(gie_on), .gie_off(gie_off), .reg_wr(reg_wr), .reg_sup(reg_sup),
      .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .acc_valid(acc_valid), .acc_idx(acc_idx)
   );

   int checks = 0;
   int errors = 0;

   // Reference state
   logic [N-1:0] lat_m = '0, msk_m = '0, pnd_m = '0;
   logic         gen_m = 1'b1;
   logic         exp_v = 1'b0;
   int           exp_i = 0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   function automatic logic [N-1:0] exp_read(input logic [1:0] s, input logic sup);
      case (s)
         2'd0: return lat_m;
         2'd1: return sup ? msk_m : '0;
         2'd2: return sup ? pnd_m : '0;
         default: return '0;
      endcase
   endfunction

   // Advance the reference by one edge from the currently driven inputs.
   task automatic model_step();
      int lp = N;
      int win = -1;
      logic [N-1:0] nl;
      for (int i = N - 1; i >= 0; i--) if (pnd_m[i]) lp = i;
      for (int i = N - 1; i >= 0; i--)
         if (i < lp && lat_m[i] && msk_m[i] && (i < GP || gen_m)) win = i;
      for (int i = 0; i < N; i++) begin
         if (reg_wr && reg_sel == 2'd0 && !msk_m[i]) nl[i] = evt_req[i] | reg_wdata[i];
         else nl[i] = evt_req[i] | (lat_m[i] && i != win);
      end
      if (evt_ret && lp < N) pnd_m[lp] = 1'b0;
      if (win >= 0) pnd_m[win] = 1'b1;
      if (reg_wr && reg_sup && reg_sel == 2'd1) msk_m = reg_wdata;
      if (gie_off) gen_m = 1'b0;
      else if (gie_on) gen_m = 1'b1;
      lat_m = nl;
      exp_v = (win >= 0);
      if (win >= 0) exp_i = win;
   endtask

   // Called at a falling edge with inputs set; checks after the rising edge.
   task automatic tick(input string tag);
      model_step();
      @(posedge clk);
      #2;
      chk({tag, " acc_valid (R10)"}, 32'(acc_valid), 32'(exp_v));
      if (exp_v) chk({tag, " acc_idx (R3)"}, 32'(acc_idx), 32'(exp_i));
      chk({tag, " rdata"}, 32'(reg_rdata), 32'(exp_read(reg_sel, reg_sup)));
      @(negedge clk);
      evt_req = '0; evt_ret = 0; gie_on = 0; gie_off = 0; reg_wr = 0;
   endtask

   task automatic wr(input logic [1:0] s, input logic [N-1:0] d, input logic sup, input string tag);
      reg_sel = s; reg_wdata = d; reg_sup = sup; reg_wr = 1'b1;
      tick(tag);
   endtask

   task automatic rd(input logic [1:0] s, input logic sup, input string tag);
      reg_sel = s; reg_sup = sup;
      tick(tag);
   endtask

   initial begin
      #(8 * 150000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1: reset state
      chk("R1 acc_valid", 32'(acc_valid), 32'd0);
      reg_sup = 1; reg_sel = 2'd0; #1 chk("R1 latch", 32'(reg_rdata), 32'd0);
      reg_sel = 2'd1; #1 chk("R1 mask", 32'(reg_rdata), 32'd0);
      reg_sel = 2'd2; #1 chk("R1 pend", 32'(reg_rdata), 32'd0);
      @(negedge clk);

      // R2: capture with mask clear, nothing issued (R4)
      evt_req = 16'h0090; rd(2'd0, 1'b0, "R2 capture");
      rd(2'd0, 1'b1, "R4 masked stays latched");

      // R5: latch write with mask clear, then with mask set on bit 9
      wr(2'd0, 16'h0300, 1'b0, "R5 unmasked write");
      reg_sup = 1'b1; gie_off = 1'b1; wr(2'd1, 16'h0200, 1'b1, "R9 off, mask bit9");
      wr(2'd0, 16'h0000, 1'b0, "R5 masked bit holds");
      rd(2'd1, 1'b1, "R9 mask untouched by switch");

      // R6: user-mode access
      wr(2'd1, 16'hFFFF, 1'b0, "R6 user mask write ignored");
      rd(2'd1, 1'b0, "R6 user mask read zero");
      wr(2'd2, 16'hFFFF, 1'b1, "R6 pend write ignored");
      rd(2'd3, 1'b1, "R6 unused select");

      // R9: enable switch issues level 9; R3 same-cycle latch/pend update
      gie_on = 1'b1; rd(2'd2, 1'b1, "R9 switch on");
      rd(2'd2, 1'b1, "R3 issue level 9");
      // R8: nesting, level 12 blocked, level 3 preempts
      wr(2'd1, 16'h1208, 1'b1, "R8 enable 3 and 12");
      evt_req = 16'h1000; rd(2'd2, 1'b1, "R8 lower priority waits");
      evt_req = 16'h0008; rd(2'd2, 1'b1, "R8 higher priority latch");
      rd(2'd2, 1'b1, "R8 preempt by level 3");
      evt_ret = 1'b1; rd(2'd2, 1'b1, "R7 retire level 3");
      evt_ret = 1'b1; rd(2'd2, 1'b1, "R7 retire level 9");
      rd(2'd2, 1'b1, "R8 level 12 issued after returns");
      evt_ret = 1'b1; gie_on = 1'b1; gie_off = 1'b1; rd(2'd2, 1'b1, "R9 off wins");

      // Constrained random
      for (int n = 0; n < 4000; n++) begin
         evt_req   = N'($urandom & $urandom & $urandom);
         evt_ret   = ($urandom % 4) == 0;
         gie_on    = ($urandom % 16) == 0;
         gie_off   = ($urandom % 24) == 0;
         reg_wr    = ($urandom % 6) == 0;
         reg_sel   = 2'($urandom);
         reg_sup   = ($urandom % 5) != 0;
         reg_wdata = N'($urandom);
         tick("R3 random");
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule